// File: doc/BRIEF.md
# Page-Bounded Flash Write Splitter

This block sits on the host side of a serial NOR flash controller. It accepts one write request, given as a start address and a byte length, and turns it into a series of page-program commands. No command carries data across a page boundary. For each command it presents the command address and byte count on a handshake, then forwards exactly that many bytes from an upstream byte stream to a downstream byte stream. After the last byte of a command, it waits for a done strobe from the serial engine before it issues the next command.

The page size is chosen per request by a select input and latched when the request is accepted. Because the first chunk can start anywhere inside a page, it may be short and unaligned. Every later chunk starts on a page boundary and carries a whole page, except possibly the last. A request of length zero finishes without issuing any command. A busy flag covers the whole request, and a one-cycle done pulse closes it.

Top module: `nor_page_splitter`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `cmdValid`, `outValid`, `inReady` and `reqDone` are 0 and `reqReady` is 1.
- R2: Every issued `cmdCount` is between 1 and the page size. `cmdAddr` modulo the page size plus `cmdCount` never exceeds the page size.
- R3: The first command of a request has address equal to the request address and count min(page size − (address mod page size), length).
- R4: Every later command starts on a page boundary and carries a full page, except the final command, which carries the remainder.
- R5: `pageSel` = 0 selects 256-byte pages and `pageSel` = 1 selects 512-byte pages. The value is sampled only in the cycle the request is accepted.
- R6: After each command handshake, exactly `cmdCount` bytes pass from `inData` to `outData` unchanged, with `outValid` = `inValid` and `inReady` = `outReady`. Outside that data phase, `inReady` and `outValid` stay 0.
- R7: `cmdValid` rises again only after a `cmdDone` pulse that arrives once the current command's bytes are all transferred. A `cmdDone` at any other time is ignored.
- R8: Each command address equals the previous command address plus the previous count, modulo 2^ADDR_W. The counts of one request add up to its length.
- R9: A zero-length request causes no command and pulses `reqDone` in the cycle after acceptance.
- R10: `busy` is 1 from the cycle after acceptance through the `reqDone` cycle, and `reqReady` is its inverse. A request offered while busy is ignored. `reqDone` is a single-cycle pulse that follows the `cmdDone` of the last command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request offered |
| reqReady | output | 1 | Request can be accepted (idle) |
| reqAddr | input | ADDR_W | Request start byte address |
| reqLen | input | LEN_W | Request length in bytes |
| pageSel | input | 1 | 0 = 256-byte page, 1 = 512-byte page |
| cmdValid | output | 1 | Page-program command presented |
| cmdReady | input | 1 | Command accepted by the serial engine |
| cmdAddr | output | ADDR_W | Command start address |
| cmdCount | output | LARGE_LOG+1 | Command byte count |
| cmdDone | input | 1 | Serial engine finished the current command |
| inData | input | DATA_W | Upstream data byte |
| inValid | input | 1 | Upstream byte valid |
| inReady | output | 1 | Upstream byte taken |
| outData | output | DATA_W | Downstream data byte |
| outValid | output | 1 | Downstream byte valid |
| outReady | input | 1 | Downstream byte taken |
| busy | output | 1 | A request is in progress |
| reqDone | output | 1 | One-cycle request completion pulse |

## Verification
The assertions assume the serial engine sends `cmdDone` as a single-cycle strobe. They also assume the request length plus the start address does not pass the top of the address range in a way that matters to the caller. The remaining-length register is never allowed to go below the registered chunk. The stimulus keeps to these assumptions: lengths stay far below the address range, and each done is a one-cycle pulse. Stray done pulses are added on purpose only while a command is being offered or its bytes are moving, which the block must ignore. Handshake inputs follow fixed, uneven patterns, so stalls on the command, upstream and downstream sides overlap in many combinations.

// File: rtl/nor_split_pkg.sv
package nor_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_WAIT,
    ST_FIN
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic issue;
    logic beat;
    logic advance;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic lenZero;
    logic lastBeat;
    logic lastChunk;
  } dpStat_t;

endpackage

// File: rtl/split_dp.sv
module split_dp
  import nor_split_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int SMALL_LOG = 8,
  parameter int LARGE_LOG = 9,
  localparam int CNT_W    = LARGE_LOG + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              pageSel,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [CNT_W-1:0]  cmdCount,
  output dpStat_t           stat
);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic              selQ;
  logic              firstQ;
  logic [CNT_W-1:0]  chunkQ;
  logic [CNT_W-1:0]  beatCnt;

  logic [CNT_W-1:0]  pageBytes;
  logic [CNT_W-1:0]  offset;
  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  chunk;

  // page geometry of the latched request
  assign pageBytes = selQ ? CNT_W'(1 << LARGE_LOG) : CNT_W'(1 << SMALL_LOG);
  assign offset    = curAddr[CNT_W-1:0] & (pageBytes - CNT_W'(1));
  assign room      = pageBytes - offset;
  assign chunk     = (remLen < LEN_W'(room)) ? remLen[CNT_W-1:0] : room;

  assign cmdAddr  = curAddr;
  assign cmdCount = chunk;

  assign stat.lenZero   = (reqLen == '0);
  assign stat.lastBeat  = (beatCnt == CNT_W'(1));
  assign stat.lastChunk = (remLen == LEN_W'(chunkQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      selQ    <= 1'b0;
      firstQ  <= 1'b0;
      chunkQ  <= '0;
      beatCnt <= '0;
    end else begin
      if (ctl.load) begin
        curAddr <= reqAddr;
        remLen  <= reqLen;
        selQ    <= pageSel;
        firstQ  <= 1'b1;
      end
      if (ctl.issue) begin
        chunkQ  <= chunk;
        beatCnt <= chunk;
        firstQ  <= 1'b0;
      end else if (ctl.beat) begin
        beatCnt <= beatCnt - CNT_W'(1);
      end
      if (ctl.advance) begin
        curAddr <= curAddr + ADDR_W'(chunkQ);
        remLen  <= remLen - LEN_W'(chunkQ);
      end
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> (chunk != '0) && (chunk <= pageBytes));

  a_r4_aligned_start: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && !firstQ) |-> (offset == '0));

  a_r4_full_page: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && !firstQ && (remLen >= LEN_W'(pageBytes))) |-> (chunk == pageBytes));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beat |-> (beatCnt != '0));

  a_r8_rem_covers: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (remLen >= LEN_W'(chunkQ)));

endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import nor_split_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdReady,
  input  logic    cmdDone,
  input  logic    inValid,
  input  logic    outReady,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    reqReady,
  output logic    cmdValid,
  output logic    inReady,
  output logic    outValid,
  output logic    busy,
  output logic    reqDone
);

  splitState_t state, stateNext;
  logic accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign cmdValid = (state == ST_CMD);
  assign inReady  = (state == ST_DATA) && outReady;
  assign outValid = (state == ST_DATA) && inValid;
  assign busy     = (state != ST_IDLE);
  assign reqDone  = (state == ST_FIN);

  assign ctl.load    = accept;
  assign ctl.issue   = cmdValid && cmdReady;
  assign ctl.beat    = (state == ST_DATA) && inValid && outReady;
  assign ctl.advance = (state == ST_WAIT) && cmdDone;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept)    stateNext = stat.lenZero ? ST_FIN : ST_CMD;
      ST_CMD:  if (ctl.issue) stateNext = ST_DATA;
      ST_DATA: if (ctl.beat && stat.lastBeat) stateNext = ST_WAIT;
      ST_WAIT: if (cmdDone)   stateNext = stat.lastChunk ? ST_FIN : ST_CMD;
      ST_FIN:                 stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !cmdDone) |=> (state == ST_WAIT));

  a_r7_issue_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> ($past(state) == ST_IDLE || $past(cmdDone)));

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (accept && stat.lenZero) |=> reqDone);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> (!reqDone && !busy));

endmodule

// File: rtl/nor_page_splitter.sv
module nor_page_splitter
  import nor_split_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 8,
  parameter int SMALL_LOG = 8,
  parameter int LARGE_LOG = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic                 pageSel,
  output logic                 cmdValid,
  input  logic                 cmdReady,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [LARGE_LOG:0]   cmdCount,
  input  logic                 cmdDone,
  input  logic [DATA_W-1:0]    inData,
  input  logic                 inValid,
  output logic                 inReady,
  output logic [DATA_W-1:0]    outData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 busy,
  output logic                 reqDone
);

  dpCtrl_t ctl;
  dpStat_t stat;

  split_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .cmdDone  (cmdDone),
    .inValid  (inValid),
    .outReady (outReady),
    .stat     (stat),
    .ctl      (ctl),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .inReady  (inReady),
    .outValid (outValid),
    .busy     (busy),
    .reqDone  (reqDone)
  );

  split_dp #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .SMALL_LOG (SMALL_LOG),
    .LARGE_LOG (LARGE_LOG)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .pageSel  (pageSel),
    .cmdAddr  (cmdAddr),
    .cmdCount (cmdCount),
    .stat     (stat)
  );

  // bytes flow straight through during the data phase
  assign outData = inData;

  a_r6_gated_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!inReady && !outValid && !cmdValid));

  a_r10_ready_inverse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == !busy);

endmodule

// File: tb/nor_page_splitter_tb_top.sv
module nor_page_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady;
  logic [23:0] reqAddr;
  logic [15:0] reqLen;
  logic        pageSel;
  logic        cmdValid, cmdReady;
  logic [23:0] cmdAddr;
  logic [9:0]  cmdCount;
  logic        cmdDone;
  logic [7:0]  inData, outData;
  logic        inValid, inReady, outValid, outReady;
  logic        busy, reqDone;

  always #4 clk = ~clk;

  nor_page_splitter dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .pageSel(pageSel),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .cmdCount(cmdCount), .cmdDone(cmdDone),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .busy(busy), .reqDone(reqDone)
  );

  int tests = 0, fails = 0;
  int phase = 0;       // 0 idle,1 cmd,2 data,3 wait,4 finish
  int qAddr[$], qCnt[$];
  int beatsLeft = 0, waitCnt = 0, chunkIdx = 0;
  int curLen = 0, curSel = 0, beatTotal = 0;
  int cyc = 0;
  bit spur = 1'b0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // downstream / upstream agent and watchdog
  always @(negedge clk) begin
    cyc++;
    cmdReady = (cyc % 3) != 0;
    inValid  = (cyc % 4) != 1;
    outReady = (cyc % 5) != 2;
    inData   = 8'(cyc * 7 + 3);
    if (phase == 3) waitCnt++; else waitCnt = 0;
    cmdDone = (phase == 3 && waitCnt >= 2) ||
              (spur && (phase == 1 || phase == 2) && (cyc % 6 == 0));
    if (cyc > 150000) begin
      chk(1'b0, "WD", "watchdog expired", cyc, 150000);
      summary();
    end
  end

  // behavioural reference, compared every cycle
  always @(negedge clk) begin
    #3;
    if (!rstN) begin
      chk(busy == 0 && cmdValid == 0 && outValid == 0 && inReady == 0 &&
          reqDone == 0 && reqReady == 1, "R1", "reset state", busy, 0);
    end else begin
      case (phase)
        0: begin
          chk(reqReady == 1 && busy == 0 && reqDone == 0, "R10", "idle flags", busy, 0);
          chk(cmdValid == 0, "R7", "no cmd when idle", cmdValid, 0);
          chk(inReady == 0 && outValid == 0, "R6", "stream gated when idle", outValid, 0);
          if (reqValid) begin
            automatic int ps = pageSel ? 512 : 256;
            automatic int a = int'(reqAddr);
            automatic int rem = int'(reqLen);
            curLen = rem; curSel = pageSel; chunkIdx = 0; beatTotal = 0;
            while (rem > 0) begin
              automatic int c = ps - (a % ps);
              if (c > rem) c = rem;
              qAddr.push_back(a); qCnt.push_back(c);
              a = (a + c) & 24'hFFFFFF; rem -= c;
            end
            phase = (qCnt.size() == 0) ? 4 : 1;
          end
        end
        1: begin
          chk(busy == 1 && reqReady == 0, "R10", "busy during cmd", busy, 1);
          chk(cmdValid == 1, "R7", "cmd offered", cmdValid, 1);
          chk(inReady == 0 && outValid == 0, "R6", "stream gated in cmd", outValid, 0);
          chk(int'(cmdAddr) == qAddr[0], "R8", "cmd address", cmdAddr, qAddr[0]);
          chk(int'(cmdCount) <= (curSel ? 512 : 256), "R2", "count within page", cmdCount, curSel ? 512 : 256);
          chk(int'(cmdCount) == qCnt[0], curSel ? "R5" : (chunkIdx == 0 ? "R3" : "R4"),
              "cmd count", cmdCount, qCnt[0]);
          if (cmdReady) begin
            beatsLeft = qCnt[0]; phase = 2;
          end
        end
        2: begin
          chk(busy == 1 && reqReady == 0, "R10", "busy during data", busy, 1);
          chk(cmdValid == 0, "R7", "no cmd in data", cmdValid, 0);
          chk(outValid == inValid && inReady == outReady, "R6", "handshake pass", outValid, inValid);
          if (inValid) chk(outData == inData, "R6", "data pass", outData, inData);
          if (inValid && outReady) begin
            beatsLeft--; beatTotal++;
            if (beatsLeft == 0) phase = 3;
          end
        end
        3: begin
          chk(busy == 1 && reqDone == 0, "R10", "busy while waiting", busy, 1);
          chk(cmdValid == 0, "R7", "no cmd before done", cmdValid, 0);
          chk(inReady == 0 && outValid == 0, "R6", "stream gated in wait", outValid, 0);
          if (cmdDone) begin
            void'(qAddr.pop_front()); void'(qCnt.pop_front());
            chunkIdx++;
            phase = (qCnt.size() == 0) ? 4 : 1;
          end
        end
        default: begin
          chk(reqDone == 1 && busy == 1, curLen == 0 ? "R9" : "R10", "done pulse", reqDone, 1);
          chk(cmdValid == 0, "R9", "no cmd at finish", cmdValid, 0);
          chk(beatTotal == curLen, "R8", "bytes sum to length", beatTotal, curLen);
          phase = 0;
        end
      endcase
    end
  end

  task automatic doReq(int addr, int len, bit sel);
    @(negedge clk);
    while (phase != 0) @(negedge clk);
    reqValid = 1'b1; reqAddr = 24'(addr); reqLen = 16'(len); pageSel = sel;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 24'hFFFFFF; reqLen = 16'hFFFF; pageSel = ~sel; // R5 latched
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqLen = '0; pageSel = 1'b0;
    cmdReady = 1'b0; cmdDone = 1'b0; inValid = 1'b0; outReady = 1'b0; inData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    doReq(64, 100, 0);           // R3 mid-page, short
    doReq('hFE, 3, 0);           // R3/R4 wrap across boundary
    spur = 1'b1;
    doReq(64, 1000, 1);          // R5 R7 large pages with stray done
    spur = 1'b0;
    doReq(0, 0, 0);              // R9 zero length
    doReq('h1F0, 600, 0);        // R4 full middle pages
    doReq(0, 512, 1);            // R2 exactly one large page
    doReq('h100, 256, 0);        // R2 exactly one small page
    doReq(5, 0, 1);              // R9 zero length, unaligned
    doReq(3, 900, 0);            // R10 request offered while busy is ignored
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqAddr = 24'h10; reqLen = 16'd5; pageSel = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    while (phase != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    summary();
  end

endmodule